// File: doc/BRIEF.md
# Read Data Output Pipeline with Programmable Latency

This block sits between the array-access stage of a synchronous DRAM model and its data pins. Each clock the access stage may present one 32-bit read word together with a valid flag. The block holds that word for a programmed number of clocks, either two or three, counted from the edge that samples it. It then presents the word on the data-out bus with a per-byte drive enable and a word-level valid flag. Four byte-mask inputs take away drive from individual byte lanes. They act with a fixed two-clock delay on the read side and at once on the write side. A burst-stop or precharge event blanks the output slot that falls exactly one programmed latency after the event.

The inbound stream has no back-pressure: the block is always ready, and the access stage may assert a valid word on every clock with no gaps. A word is consumed on every rising edge at which its valid is high and reset is released. The latency is taken from a configuration pin only on edges where a load strobe is high. Reprogramming it while read words are still in the pipeline is not supported.

Top module: `read_data_pipe`

## Requirements
- R1: While reset is asserted and after its release, dq_valid is 0, dq_oe is 4'b0000 and dq_out is zero, and the latency setting is three clocks.
- R2: With latency two, a word accepted at rising edge n (rd_valid high, no stop or precharge) is seen at edge n+2 with dq_valid high and dq_out equal to the word on every driven lane.
- R3: With latency three, a word accepted at rising edge n is seen at edge n+3 in the same way.
- R4: The latency setting changes only at an edge where cfg_load is 1, taking three clocks when cfg_lat3 is 1 and two clocks when it is 0; cfg_lat3 has no effect at other edges.
- R5: Words accepted on consecutive edges leave on consecutive edges, in order, with no gap or repeat.
- R6: Mask bit dqm[i] (lane i is dq_out[8i+7:8i]) sampled high at edge m drops dq_oe[i] and forces that lane of dq_out to zero at edge m+2, for either latency; lanes whose dq_oe bit is 0 always read zero.
- R7: dq_valid marks a read slot whatever the masks; dq_oe is nonzero only while dq_valid is 1.
- R8: rd_stop or rd_precharge high at edge p makes dq_valid and dq_oe zero at edge p+L (L the programmed latency); words accepted before p and after p are delivered as usual.
- R9: wr_byte_en equals the inverted dqm while wr_phase is 1 and is zero while wr_phase is 0, in the same cycle, with no clock delay.
- R10: The block accepts a word on every edge with no back-pressure, so a long uninterrupted stream is delivered in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Strobe that takes a new latency setting |
| cfg_lat3 | input | 1 | Latency value: 1 for three clocks, 0 for two |
| rd_valid | input | 1 | Read word present on rd_data |
| rd_data | input | 32 | Read word from the access stage |
| rd_stop | input | 1 | Burst-stop event |
| rd_precharge | input | 1 | Precharge event |
| dqm | input | 4 | Per-byte mask, one bit per lane |
| wr_phase | input | 1 | Write path active in this cycle |
| wr_byte_en | output | 4 | Per-byte write enable after masking |
| dq_out | output | 32 | Read data toward the pins |
| dq_oe | output | 4 | Per-lane output drive enable |
| dq_valid | output | 1 | Output slot carries read data |

## Verification
On every cycle the assertions check the arrival of accepted words after two or three clocks, the blanking after stop or precharge, the two-clock read mask against the mask seen two edges earlier, and that lanes without drive read zero and drive appears only in a valid slot. Only the bench scenarios can show that a load strobe is needed to change the latency, that ordering holds across long unbroken streams, that a reset in mid-stream empties the pipeline, and that the write mask follows its inputs within the same cycle.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic {
    LAT_TWO   = 1'b0,
    LAT_THREE = 1'b1
  } lat_sel_e;

  localparam int MIN_LAT = 2;
endpackage

// File: rtl/rdp_mode_reg.sv
module rdp_mode_reg
  import rdp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     lat3_in,
  output lat_sel_e lat_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_sel <= LAT_THREE;
    else if (load) lat_sel <= lat3_in ? LAT_THREE : LAT_TWO;
  end
endmodule

// File: rtl/rdp_delay_line.sv
module rdp_delay_line #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [W-1:0]            in_data,
  output logic [DEPTH-1:0]        tap_valid,
  output logic [DEPTH-1:0][W-1:0] tap_data
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic         nxt_v;
    logic [W-1:0] nxt_d;
    if (g == 0) begin : g_head
      assign nxt_v = in_valid;
      assign nxt_d = in_data;
    end else begin : g_body
      assign nxt_v = tap_valid[g-1];
      assign nxt_d = tap_data[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_valid[g] <= 1'b0;
        tap_data[g]  <= '0;
      end else begin
        tap_valid[g] <= nxt_v;
        tap_data[g]  <= nxt_v ? nxt_d : '0;
      end
    end
  end
endmodule

// File: rtl/rdp_lane_out.sv
module rdp_lane_out #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_valid,
  input  logic [LANES*LANE_W-1:0] sel_data,
  input  logic [LANES-1:0]        dqm,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic [LANES-1:0]        dq_oe,
  output logic                    dq_valid
);
  // One register stage here plus the output stage gives the fixed
  // two-clock read mask delay.
  logic [LANES-1:0] dqm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqm_q    <= '0;
      dq_valid <= 1'b0;
    end else begin
      dqm_q    <= dqm;
      dq_valid <= sel_valid;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic drive;
    assign drive = sel_valid & ~dqm_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dq_oe[g]                   <= 1'b0;
        dq_out[g*LANE_W +: LANE_W] <= '0;
      end else begin
        dq_oe[g]                   <= drive;
        dq_out[g*LANE_W +: LANE_W] <= drive ? sel_data[g*LANE_W +: LANE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/read_data_pipe.sv
module read_data_pipe
  import rdp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LANE_W  = 8,
  parameter int MAX_LAT = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_load,
  input  logic                         cfg_lat3,
  input  logic                         rd_valid,
  input  logic [DATA_W-1:0]            rd_data,
  input  logic                         rd_stop,
  input  logic                         rd_precharge,
  input  logic [DATA_W/LANE_W-1:0]     dqm,
  input  logic                         wr_phase,
  output logic [DATA_W/LANE_W-1:0]     wr_byte_en,
  output logic [DATA_W-1:0]            dq_out,
  output logic [DATA_W/LANE_W-1:0]     dq_oe,
  output logic                         dq_valid
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = MAX_LAT - MIN_LAT + 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lat_sel_e                         lat_sel;
  logic                             entry_valid;
  logic [DEPTH-1:0]                 tap_valid;
  logic [DEPTH-1:0][DATA_W-1:0]     tap_data;
  logic [IDX_W-1:0]                 tap_idx;
  logic                             sel_valid;
  logic [DATA_W-1:0]                sel_data;

  rdp_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .lat3_in (cfg_lat3),
    .lat_sel (lat_sel)
  );

  // A stop or precharge voids the slot entering now; it leaves after
  // the programmed latency, which is exactly the turn-off delay.
  assign entry_valid = rd_valid & ~(rd_stop | rd_precharge);

  rdp_delay_line #(.W(DATA_W), .DEPTH(DEPTH)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (entry_valid),
    .in_data   (rd_data),
    .tap_valid (tap_valid),
    .tap_data  (tap_data)
  );

  assign tap_idx   = (lat_sel == LAT_THREE) ? IDX_W'(1) : '0;
  assign sel_valid = tap_valid[tap_idx];
  assign sel_data  = tap_data[tap_idx];

  rdp_lane_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_valid (sel_valid),
    .sel_data  (sel_data),
    .dqm       (dqm),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .dq_valid  (dq_valid)
  );

  assign wr_byte_en = wr_phase ? ~dqm : '0;
endmodule

// File: rtl/rdp_chk.sv
module rdp_chk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_load,
  input logic                     cfg_lat3,
  input logic                     rd_valid,
  input logic [DATA_W-1:0]        rd_data,
  input logic                     rd_stop,
  input logic                     rd_precharge,
  input logic [DATA_W/LANE_W-1:0] dqm,
  input logic [DATA_W-1:0]        dq_out,
  input logic [DATA_W/LANE_W-1:0] dq_oe,
  input logic                     dq_valid
);
  localparam int LANES = DATA_W / LANE_W;

  logic              lat3_ck;
  logic [1:0]        age_q;
  logic [DATA_W-1:0] lane_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat3_ck <= 1'b1;
      age_q   <= '0;
    end else begin
      if (cfg_load) lat3_ck <= cfg_lat3;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++)
      lane_bits[i*LANE_W +: LANE_W] = {LANE_W{dq_oe[i]}};
  end

  // R2
  lat_two_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat3_ck && rd_valid && !rd_stop && !rd_precharge) |-> ##2
      (dq_valid && (((dq_out ^ $past(rd_data, 2)) & lane_bits) == '0)));

  // R3
  lat_three_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat3_ck && rd_valid && !rd_stop && !rd_precharge) |-> ##3
      (dq_valid && (((dq_out ^ $past(rd_data, 3)) & lane_bits) == '0)));

  // R8
  kill_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat3_ck && (rd_stop || rd_precharge)) |-> ##2 (!dq_valid && dq_oe == '0));

  // R8
  kill_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat3_ck && (rd_stop || rd_precharge)) |-> ##3 (!dq_valid && dq_oe == '0));

  // R6
  read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (dq_oe == ({LANES{dq_valid}} & ~$past(dqm, 2))));

  // R6
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> ((dq_out & ~lane_bits) == '0));

  // R7
  drive_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != '0) |-> dq_valid);
endmodule

bind read_data_pipe rdp_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_load     (cfg_load),
  .cfg_lat3     (cfg_lat3),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .rd_stop      (rd_stop),
  .rd_precharge (rd_precharge),
  .dqm          (dqm),
  .dq_out       (dq_out),
  .dq_oe        (dq_oe),
  .dq_valid     (dq_valid)
);

// File: tb/read_data_pipe_tb_top.sv
module read_data_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_lat3 = 1'b0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        rd_stop = 1'b0, rd_precharge = 1'b0;
  logic [3:0]  dqm = '0;
  logic        wr_phase = 1'b0;
  logic [3:0]  wr_byte_en;
  logic [31:0] dq_out;
  logic [3:0]  dq_oe;
  logic        dq_valid;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  read_data_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lat3(cfg_lat3),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_stop(rd_stop),
    .rd_precharge(rd_precharge), .dqm(dqm), .wr_phase(wr_phase),
    .wr_byte_en(wr_byte_en), .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: expected output keyed by the edge after which it shows.
  bit          exp_v[int];
  logic [31:0] exp_d[int];
  logic [3:0]  exp_m[int];
  int          edge_n = 0;
  bit          lat3_m = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v.delete(); exp_d.delete(); exp_m.delete();
      edge_n = 0;
      lat3_m = 1'b1;
    end else begin
      int lat;
      edge_n++;
      if (cfg_load) lat3_m = cfg_lat3;
      lat = lat3_m ? 3 : 2;
      exp_v[edge_n + lat - 1] = rd_valid && !rd_stop && !rd_precharge;
      exp_d[edge_n + lat - 1] = rd_data;
      exp_m[edge_n + 1]       = dqm;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit          ev;
      logic [3:0]  em, eoe;
      logic [31:0] ed, eout;
      ev  = exp_v.exists(edge_n) ? exp_v[edge_n] : 1'b0;
      em  = exp_m.exists(edge_n) ? exp_m[edge_n] : 4'h0;
      ed  = exp_d.exists(edge_n) ? exp_d[edge_n] : 32'h0;
      eoe = ev ? ~em : 4'h0;
      for (int i = 0; i < 4; i++)
        eout[i*8 +: 8] = eoe[i] ? ed[i*8 +: 8] : 8'h0;
      chk(cur_req, {27'h0, dq_valid, dq_oe, dq_out}, {27'h0, ev, eoe, eout});
    end
  end

  task automatic step(logic v, logic [31:0] d, logic [3:0] m, logic st, logic pc);
    @(negedge clk);
    rd_valid = v; rd_data = d; dqm = m; rd_stop = st; rd_precharge = pc;
    cfg_load = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic set_lat(logic l3);
    @(negedge clk);
    rd_valid = 1'b0; cfg_load = 1'b1; cfg_lat3 = l3;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {dq_valid, dq_oe, dq_out}, '0);
    rst_n = 1'b1;
    idle(2);
    chk("R1", {dq_valid, dq_oe, dq_out}, '0);

    // R3: default latency is three
    cur_req = "R3";
    step(1'b1, 32'hDEAD_BEEF, 4'h0, 1'b0, 1'b0);
    idle(5);

    // R4: cfg_lat3 without load does nothing
    cur_req = "R4";
    @(negedge clk); cfg_lat3 = 1'b0;
    step(1'b1, 32'h1234_5678, 4'h0, 1'b0, 1'b0);
    idle(5);

    // R5: back-to-back at latency three
    cur_req = "R5";
    for (int i = 0; i < 8; i++) step(1'b1, 32'hA000_0000 + i, 4'h0, 1'b0, 1'b0);
    idle(5);

    // R2: latency two
    cur_req = "R2";
    set_lat(1'b0);
    idle(2);
    step(1'b1, 32'hCAFE_F00D, 4'h0, 1'b0, 1'b0);
    idle(2);
    for (int i = 0; i < 6; i++) step(1'b1, 32'hB100_0000 + i * 3, 4'h0, 1'b0, 1'b0);
    idle(4);

    // R6: read mask at latency two, then three
    cur_req = "R6";
    for (int i = 0; i < 8; i++) step(1'b1, 32'h0102_0304 * (i + 1), 4'(i * 5), 1'b0, 1'b0);
    step(1'b0, 32'h0, 4'hF, 1'b0, 1'b0);
    idle(4);
    set_lat(1'b1);
    idle(2);
    for (int i = 0; i < 8; i++) step(1'b1, 32'h1111_1111 * (i + 1), 4'(i * 3), 1'b0, 1'b0);
    idle(4);

    // R7: fully masked slots stay valid
    cur_req = "R7";
    for (int i = 0; i < 4; i++) step(1'b1, 32'h7777_0000 + i, 4'hF, 1'b0, 1'b0);
    idle(4);

    // R8: stop and precharge at latency three, then two
    cur_req = "R8";
    for (int i = 0; i < 8; i++)
      step(1'b1, 32'hC300_0000 + i, 4'h0, (i == 3), (i == 6));
    idle(4);
    set_lat(1'b0);
    idle(2);
    for (int i = 0; i < 8; i++)
      step(1'b1, 32'hC200_0000 + i, 4'h0, (i == 2), (i == 5));
    step(1'b0, 32'h0, 4'h0, 1'b1, 1'b0);
    idle(4);

    // R9: write mask is combinational
    cur_req = "R9";
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wr_phase = i[0]; dqm = 4'(i);
      #1;
      chk("R9", {60'h0, wr_byte_en}, {60'h0, (i[0] ? ~4'(i) : 4'h0)});
    end
    @(negedge clk); wr_phase = 1'b0; dqm = '0;
    idle(3);

    // R10: long unbroken stream, both latencies
    cur_req = "R10";
    for (int i = 0; i < 40; i++) step(1'b1, 32'h9E37_79B9 * (i + 7), 4'(i % 3), 1'b0, 1'b0);
    idle(4);
    set_lat(1'b1);
    idle(2);
    for (int i = 0; i < 40; i++) step(1'b1, 32'h85EB_CA6B * (i + 3), 4'h0, 1'b0, 1'b0);

    // R1: reset in mid-stream empties the pipeline
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1", {dq_valid, dq_oe, dq_out}, '0);
    rd_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R1";
    idle(5);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule